// File: doc/BRIEF.md
# Indirect Register Bus Bridge

This bridge gives a host a small window of 64-bit words and carries single accesses across to a narrower internal register bus. The host writes one packed command word that holds the operation, the internal address and the write data. The bridge then drives the internal bus until the target accepts the request. The host polls a status word until its valid flag is set. After a read, the low half of that status word holds the returned data. A third word is read-only and reports fixed settings of a shared SPI master. These settings come from parameters.

The internal bus is a valid/ready handshake. The bridge raises `ib_valid` with `ib_we`, `ib_addr` and `ib_wdata`, and holds all of them stable until the target raises `ib_ready`. The transaction completes on the first cycle in which both are high. The target may hold `ib_ready` low for as long as it needs, which applies back-pressure. The target may also raise `ib_ready` before a request is present. For a read, the target presents `ib_rdata` in the completing cycle. Only one request is outstanding at a time. The host side is plain: a write strobe with address and data, and a combinational read port.

Top module: `ibb_bridge`

## Requirements
- R1: After reset the status word reads 0, so the valid flag and the read-data field are both 0, and `ib_valid` is 0.
- R2: Host byte offsets are fixed. The parameter word is at 0x08, the command word at 0x10 and the status word at 0x18. Reading any other offset returns 0, and reading the command offset also returns 0.
- R3: The command word carries write data in bits 31:0, the internal address in bits 44:32 and the opcode in bits 63:62. Bits 61:45 are ignored. Opcode 1 is a read and opcode 2 is a write.
- R4: A read or write command written while idle makes `ib_valid` high in the next cycle, with the decoded fields on the bus. In that same cycle the valid flag (status bit 32) reads 0.
- R5: While `ib_valid` is high and `ib_ready` is low, `ib_valid`, `ib_we`, `ib_addr` and `ib_wdata` stay unchanged.
- R6: In the cycle after the handshake, `ib_valid` is 0 and the valid flag is 1. If the transaction was a read, status bits 31:0 hold the `ib_rdata` value taken at the handshake. Status bits 63:33 always read 0.
- R7: A completed write leaves the read-data field at its previous value.
- R8: The following leave the status word and the internal bus unchanged:
  - a command with opcode 0 (no operation);
  - a command with opcode 3 (reserved);
  - any host write to an offset other than 0x10.
- R9: A command written while a transaction is in flight is ignored, so at most one request is outstanding.
- R10: The parameter word holds the SPI master settings in these bits, with all other bits 0:

| Bits | Setting |
|---|---|
| 1 | shift order: 0 MSB first, 1 LSB first |
| 7:2 | data width |
| 13:8 | chip-select count |
| 14 | clock polarity |
| 15 | clock phase |
| 47:32 | peripheral ID |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr_en | input | 1 | Host write strobe |
| h_wr_addr | input | HOST_AW | Host write byte offset |
| h_wr_data | input | 64 | Host write data |
| h_rd_addr | input | HOST_AW | Host read byte offset |
| h_rd_data | output | 64 | Host read data (combinational) |
| ib_valid | output | 1 | Internal request valid |
| ib_ready | input | 1 | Internal target ready / acknowledge |
| ib_we | output | 1 | Internal request is a write |
| ib_addr | output | IB_AW | Internal register address |
| ib_wdata | output | IB_DW | Internal write data |
| ib_rdata | input | IB_DW | Internal read data, valid at handshake |

## Verification
The hardest case to reach from the ports is a second command that lands while the first is still waiting for `ib_ready`. To reach it, the bench's target model stretches its acknowledge by several cycles, and a second command is written directly behind the first. The bench then checks three things: exactly one handshake occurs, it carries the first command's fields, and the bus stays idle afterwards. Opcodes 0 and 3 are applied after a completed read, so that any disturbance of the held status would be visible.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_RSV = 2'd3
  } ibb_op_e;

  localparam int OFS_PARAM  = 8;
  localparam int OFS_CMD    = 16;
  localparam int OFS_STATUS = 24;

  localparam int CMD_ADDR_LSB = 32;
  localparam int CMD_OP_LSB   = 62;
  localparam int STAT_VLD_BIT = 32;
endpackage

// File: rtl/ibb_cmd_decode.sv
module ibb_cmd_decode
  import ibb_pkg::*;
#(
  parameter int HOST_AW = 5,
  parameter int IB_AW   = 13,
  parameter int IB_DW   = 32
) (
  input  logic               h_wr_en,
  input  logic [HOST_AW-1:0] h_wr_addr,
  input  logic [63:0]        h_wr_data,
  output logic               launch,
  output logic               launch_we,
  output logic [IB_AW-1:0]   launch_addr,
  output logic [IB_DW-1:0]   launch_wdata
);
  ibb_op_e op;

  always_comb begin
    op           = ibb_op_e'(h_wr_data[CMD_OP_LSB +: 2]);
    launch_we    = (op == OP_WR);
    launch_addr  = h_wr_data[CMD_ADDR_LSB +: IB_AW];
    launch_wdata = h_wr_data[IB_DW-1:0];
    launch       = h_wr_en && (h_wr_addr == HOST_AW'(OFS_CMD)) &&
                   ((op == OP_RD) || (op == OP_WR));
  end
endmodule

// File: rtl/ibb_engine.sv
module ibb_engine #(
  parameter int IB_AW = 13,
  parameter int IB_DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             launch_we,
  input  logic [IB_AW-1:0] launch_addr,
  input  logic [IB_DW-1:0] launch_wdata,
  output logic             ib_valid,
  input  logic             ib_ready,
  output logic             ib_we,
  output logic [IB_AW-1:0] ib_addr,
  output logic [IB_DW-1:0] ib_wdata,
  input  logic [IB_DW-1:0] ib_rdata,
  output logic             stat_valid,
  output logic [IB_DW-1:0] stat_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ib_valid   <= 1'b0;
      ib_we      <= 1'b0;
      ib_addr    <= '0;
      ib_wdata   <= '0;
      stat_valid <= 1'b0;
      stat_rdata <= '0;
    end else if (ib_valid) begin
      if (ib_ready) begin
        ib_valid   <= 1'b0;
        stat_valid <= 1'b1;
        if (!ib_we) stat_rdata <= ib_rdata;
      end
    end else if (launch) begin
      ib_valid   <= 1'b1;
      ib_we      <= launch_we;
      ib_addr    <= launch_addr;
      ib_wdata   <= launch_wdata;
      stat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ibb_window.sv
module ibb_window
  import ibb_pkg::*;
#(
  parameter int          HOST_AW       = 5,
  parameter int          IB_DW         = 32,
  parameter bit          SPI_LSB_FIRST = 1'b0,
  parameter int          SPI_WIDTH     = 32,
  parameter int          SPI_NUM_CS    = 1,
  parameter bit          SPI_CPOL      = 1'b0,
  parameter bit          SPI_CPHA      = 1'b0,
  parameter logic [15:0] SPI_PERIPH_ID = 16'h00C5
) (
  input  logic [HOST_AW-1:0] h_rd_addr,
  input  logic               stat_valid,
  input  logic [IB_DW-1:0]   stat_rdata,
  output logic [63:0]        h_rd_data
);
  localparam logic [5:0] WIDTH_F = 6'(SPI_WIDTH);
  localparam logic [5:0] CS_F    = 6'(SPI_NUM_CS);
  localparam logic [63:0] PARAM_WORD =
    {16'h0, SPI_PERIPH_ID, 16'h0, SPI_CPHA, SPI_CPOL, CS_F, WIDTH_F,
     SPI_LSB_FIRST, 1'b0};

  logic [63:0] status_word;

  always_comb begin
    status_word = '0;
    status_word[IB_DW-1:0]    = stat_rdata;
    status_word[STAT_VLD_BIT] = stat_valid;
    if (h_rd_addr == HOST_AW'(OFS_PARAM))       h_rd_data = PARAM_WORD;
    else if (h_rd_addr == HOST_AW'(OFS_STATUS)) h_rd_data = status_word;
    else                                         h_rd_data = '0;
  end
endmodule

// File: rtl/ibb_bridge.sv
module ibb_bridge #(
  parameter int          HOST_AW       = 5,
  parameter int          IB_AW         = 13,
  parameter int          IB_DW         = 32,
  parameter bit          SPI_LSB_FIRST = 1'b0,
  parameter int          SPI_WIDTH     = 32,
  parameter int          SPI_NUM_CS    = 1,
  parameter bit          SPI_CPOL      = 1'b0,
  parameter bit          SPI_CPHA      = 1'b0,
  parameter logic [15:0] SPI_PERIPH_ID = 16'h00C5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_wr_en,
  input  logic [HOST_AW-1:0] h_wr_addr,
  input  logic [63:0]        h_wr_data,
  input  logic [HOST_AW-1:0] h_rd_addr,
  output logic [63:0]        h_rd_data,
  output logic               ib_valid,
  input  logic               ib_ready,
  output logic               ib_we,
  output logic [IB_AW-1:0]   ib_addr,
  output logic [IB_DW-1:0]   ib_wdata,
  input  logic [IB_DW-1:0]   ib_rdata
);
  logic             launch;
  logic             launch_we;
  logic [IB_AW-1:0] launch_addr;
  logic [IB_DW-1:0] launch_wdata;
  logic             stat_valid;
  logic [IB_DW-1:0] stat_rdata;

  ibb_cmd_decode #(.HOST_AW(HOST_AW), .IB_AW(IB_AW), .IB_DW(IB_DW)) u_dec (
    .h_wr_en(h_wr_en), .h_wr_addr(h_wr_addr), .h_wr_data(h_wr_data),
    .launch(launch), .launch_we(launch_we),
    .launch_addr(launch_addr), .launch_wdata(launch_wdata)
  );

  ibb_engine #(.IB_AW(IB_AW), .IB_DW(IB_DW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_we(launch_we),
    .launch_addr(launch_addr), .launch_wdata(launch_wdata),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_we(ib_we),
    .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_rdata(ib_rdata),
    .stat_valid(stat_valid), .stat_rdata(stat_rdata)
  );

  ibb_window #(
    .HOST_AW(HOST_AW), .IB_DW(IB_DW), .SPI_LSB_FIRST(SPI_LSB_FIRST),
    .SPI_WIDTH(SPI_WIDTH), .SPI_NUM_CS(SPI_NUM_CS), .SPI_CPOL(SPI_CPOL),
    .SPI_CPHA(SPI_CPHA), .SPI_PERIPH_ID(SPI_PERIPH_ID)
  ) u_win (
    .h_rd_addr(h_rd_addr), .stat_valid(stat_valid),
    .stat_rdata(stat_rdata), .h_rd_data(h_rd_data)
  );
endmodule

// File: rtl/ibb_checker.sv
module ibb_checker
  import ibb_pkg::*;
#(
  parameter int HOST_AW = 5,
  parameter int IB_AW   = 13,
  parameter int IB_DW   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               h_wr_en,
  input logic [HOST_AW-1:0] h_wr_addr,
  input logic [63:0]        h_wr_data,
  input logic               ib_valid,
  input logic               ib_ready,
  input logic               ib_we,
  input logic [IB_AW-1:0]   ib_addr,
  input logic [IB_DW-1:0]   ib_wdata,
  input logic [IB_DW-1:0]   ib_rdata,
  input logic               stat_valid,
  input logic [IB_DW-1:0]   stat_rdata
);
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid && !ib_ready |=> ib_valid && $stable(ib_addr) &&
                              $stable(ib_wdata) && $stable(ib_we));

  a_r4_flag_low_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid |-> !stat_valid);

  a_r6_completion: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid && ib_ready |=> !ib_valid && stat_valid);

  a_r6_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid && ib_ready && !ib_we |=> stat_rdata == $past(ib_rdata));

  a_r7_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid && ib_ready && ib_we |=> $stable(stat_rdata));

  a_r8_request_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ib_valid) |-> $past(h_wr_en && (h_wr_addr == HOST_AW'(OFS_CMD)) &&
      ((h_wr_data[63:62] == 2'd1) || (h_wr_data[63:62] == 2'd2))));
endmodule

bind ibb_bridge ibb_checker #(.HOST_AW(HOST_AW), .IB_AW(IB_AW), .IB_DW(IB_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_wr_addr(h_wr_addr),
  .h_wr_data(h_wr_data), .ib_valid(ib_valid), .ib_ready(ib_ready),
  .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
  .ib_rdata(ib_rdata), .stat_valid(stat_valid), .stat_rdata(stat_rdata)
);

// File: tb/tb_ibb_bridge.sv
`timescale 1ns/1ps
module tb_ibb_bridge;
  localparam int HOST_AW = 5;
  localparam int IB_AW   = 13;
  localparam int IB_DW   = 32;
  localparam logic [63:0] EXP_PARAM = 64'h0000_00C5_0000_8182;
  localparam logic [4:0] A_PARAM = 5'h08, A_CMD = 5'h10, A_STAT = 5'h18;
  localparam int NV = 6;
  localparam logic [63:0] VCMD [NV] = '{
    {2'd1, 17'h0,     13'h0040, 32'h0000_0000},
    {2'd2, 17'h0,     13'h0104, 32'hDEAD_BEEF},
    {2'd1, 17'h0,     13'h1FFC, 32'h1234_5678},
    {2'd2, 17'h1ABCD, 13'h0000, 32'hFFFF_FFFF},
    {2'd1, 17'h0,     13'h0008, 32'h0},
    {2'd2, 17'h0,     13'h1000, 32'h0000_0001}
  };
  localparam int VDLY [NV] = '{0, 2, 3, 0, 7, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr_en = 1'b0;
  logic [HOST_AW-1:0] h_wr_addr = '0;
  logic [63:0] h_wr_data = '0;
  logic [HOST_AW-1:0] h_rd_addr = A_STAT;
  logic [63:0] h_rd_data;
  logic ib_valid, ib_we, ib_ready = 1'b0;
  logic [IB_AW-1:0] ib_addr;
  logic [IB_DW-1:0] ib_wdata, ib_rdata;

  int checks = 0, failures = 0;
  int dly = 0, cnt = 0;
  int hs_cnt = 0;
  logic hs_we;
  logic [IB_AW-1:0] hs_addr;
  logic [IB_DW-1:0] hs_wdata;
  logic [31:0] last_rd;

  always #2.5 clk = ~clk;

  ibb_bridge #(
    .HOST_AW(HOST_AW), .IB_AW(IB_AW), .IB_DW(IB_DW), .SPI_LSB_FIRST(1'b1),
    .SPI_WIDTH(32), .SPI_NUM_CS(1), .SPI_CPOL(1'b0), .SPI_CPHA(1'b1),
    .SPI_PERIPH_ID(16'h00C5)
  ) dut (
    .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_wr_addr(h_wr_addr),
    .h_wr_data(h_wr_data), .h_rd_addr(h_rd_addr), .h_rd_data(h_rd_data),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_we(ib_we),
    .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_rdata(ib_rdata)
  );

  function automatic logic [31:0] rmod(input logic [IB_AW-1:0] a);
    return {8'hA5, 11'h0, a};
  endfunction
  assign ib_rdata = rmod(ib_addr);

  // target model: ready after dly cycles of valid
  always @(negedge clk) begin
    if (ib_valid) begin
      ib_ready = (cnt >= dly);
      cnt++;
    end else begin
      ib_ready = 1'b0;
      cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && ib_valid && ib_ready) begin
      hs_cnt++;
      hs_we = ib_we;
      hs_addr = ib_addr;
      hs_wdata = ib_wdata;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    h_wr_en = 1'b1; h_wr_addr = a; h_wr_data = d;
    @(negedge clk);
    h_wr_en = 1'b0;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    h_rd_addr = A_STAT;
    for (int i = 0; i < 40; i++) begin
      if (h_rd_data[32]) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ok;
    int base;
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    h_rd_addr = A_STAT;
    chk("R1 status", h_rd_data, 64'h0);
    chk("R1 ib_valid", {63'h0, ib_valid}, 64'h0);
    // R10 / R2 window
    h_rd_addr = A_PARAM; #0.1;
    chk("R10 param word", h_rd_data, EXP_PARAM);
    h_rd_addr = A_CMD; #0.1;
    chk("R2 cmd reads zero", h_rd_data, 64'h0);
    h_rd_addr = 5'h00; #0.1;
    chk("R2 unmapped", h_rd_data, 64'h0);
    h_rd_addr = A_STAT;
    last_rd = 32'h0;

    // vector table
    for (int v = 0; v < NV; v++) begin
      dly = VDLY[v];
      base = hs_cnt;
      hwrite(A_CMD, VCMD[v]);
      chk("R4 flag cleared", {63'h0, h_rd_data[32]}, 64'h0);
      chk("R4 request raised", {63'h0, ib_valid}, 64'h1);
      wait_valid(ok);
      chk("R6 completed", {63'h0, ok}, 64'h1);
      chk("R6 one handshake", 64'(hs_cnt - base), 64'h1);
      chk("R3 addr", 64'(hs_addr), 64'(VCMD[v][44:32]));
      chk("R3 we", {63'h0, hs_we}, {63'h0, VCMD[v][63:62] == 2'd2});
      if (VCMD[v][63:62] == 2'd2) begin
        chk("R3 wdata", 64'(hs_wdata), 64'(VCMD[v][31:0]));
        chk("R7 rdata kept", 64'(h_rd_data[31:0]), 64'(last_rd));
      end else begin
        last_rd = rmod(VCMD[v][44:32]);
        chk("R6 rdata", 64'(h_rd_data[31:0]), 64'(last_rd));
      end
      chk("R6 upper zero", 64'(h_rd_data[63:33]), 64'h0);
      chk("R6 bus idle", {63'h0, ib_valid}, 64'h0);
    end

    // R8 no-op, reserved, wrong offset
    dly = 0;
    hwrite(A_CMD, {2'd1, 17'h0, 13'h0ABC, 32'h0});
    wait_valid(ok);
    snap = h_rd_data[31:0];
    base = hs_cnt;
    hwrite(A_CMD, {2'd0, 17'h0, 13'h0111, 32'h5});
    repeat (3) @(negedge clk);
    chk("R8 nop status", h_rd_data, {31'h0, 1'b1, snap});
    hwrite(A_CMD, {2'd3, 17'h0, 13'h0222, 32'h6});
    repeat (3) @(negedge clk);
    chk("R8 reserved status", h_rd_data, {31'h0, 1'b1, snap});
    hwrite(A_PARAM, {2'd1, 17'h0, 13'h0333, 32'h7});
    hwrite(A_STAT, {2'd2, 17'h0, 13'h0444, 32'h8});
    repeat (3) @(negedge clk);
    chk("R8 other offsets status", h_rd_data, {31'h0, 1'b1, snap});
    chk("R8 no handshake", 64'(hs_cnt - base), 64'h0);
    chk("R8 bus idle", {63'h0, ib_valid}, 64'h0);

    // R9 command while in flight
    dly = 4;
    base = hs_cnt;
    hwrite(A_CMD, {2'd1, 17'h0, 13'h0AA0, 32'h0});
    hwrite(A_CMD, {2'd2, 17'h0, 13'h0BB0, 32'hCAFE_F00D});
    chk("R9 original addr held", 64'(ib_addr), 64'h0AA0);
    wait_valid(ok);
    repeat (6) @(negedge clk);
    chk("R9 single handshake", 64'(hs_cnt - base), 64'h1);
    chk("R9 first command kept", 64'(hs_addr), 64'h0AA0);
    chk("R9 read result", 64'(h_rd_data[31:0]), 64'(rmod(13'h0AA0)));
    chk("R9 no second request", {63'h0, ib_valid}, 64'h0);

    // R1 reset again clears status
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", h_rd_data, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule